// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the mode-control state machine of a small system controller. Software asks for a low-power mode. The sequencer then drives the control lines for the processor clock gate, the master clock source, the fast RC oscillator enable, the regulator mode and voltage step, the core power switch, the core reset, the supply-controller power and the pad reinitialisation request. The analog parts are outside the block. They appear only as enable lines and as the `osc_ready` / `reg_ready` flags. A separate detector turns wake-up sources into single-cycle pulses before they arrive here.

Each mode has its own exit path:
- **Idle** leaves on an interrupt pulse.
- **Wait** leaves on a fast start-up pulse. The exit restarts the fast RC oscillator, waits until it is ready and then moves the master clock back onto it.
- **Backup** powers the core up again, with the regulator first and the oscillator second, and only then releases core reset.
- **Off** first restores the supply controller and then follows the backup path.

Every wait for a ready flag is bounded by a timeout counter. A request that arrives outside active mode is parked and runs once active mode is reached again.

Top module: `lpm_sequencer`

## Requirements
- R1: Mode request codes are 1 = idle, 2 = wait, 3 = backup and 4 = off. Codes 0, 5, 6 and 7 are ignored. A valid request that is pulsed in active mode is visible on the outputs two clock edges after it is sampled.
- R2: In idle, only `cpu_clk_en` is low, and the master clock stays on the fast RC oscillator. An `irq_wake` pulse returns the block to active at the next edge. The other wake pulses have no effect in idle.
- R3: Wait stops the processor clock and the fast RC oscillator, selects the slow clock and sets `reg_mode` = 1 (deep). Only `fast_wake` leaves wait.
- R4: On the wait exit, `fastrc_en` rises and `reg_mode` returns to 0 (normal), while `mck_on_fastrc` and `cpu_clk_en` stay low. Both go high together on the edge after `osc_ready` is seen. If `osc_ready` never comes, they go high after `TMO_CYCLES` cycles of waiting.
- R5: Backup sets `reg_mode` = 2 (shutdown) and `core_pwr_en` = 0, holds `core_rst` high and keeps `sys_pwr_en` high. `bkp_sram_en` follows the `bkp_sram_keep` value captured on entry. A `bkp_wake` or `force_wake` pulse starts the exit.
- R6: A power-up exit first drives `reg_mode` = 0, `core_pwr_en` = 1 and `bkp_sram_en` = 1 with the oscillator off. It stays there until `reg_ready` is seen, but for at most `TMO_CYCLES` cycles. It then enables the oscillator and waits for `osc_ready` in the same way. Core reset is released only after both steps.
- R7: During any ready wait, `wait_timeout` is high for exactly one cycle, in the last cycle of a wait that ends without the awaited flag.
- R8: `pad_reinit` is high for exactly one cycle at the end of a backup or off exit, while core reset is still held. It never rises in idle or wait, or on their exits.
- R9: Off drives every power, clock and enable output low, including `sys_pwr_en`. Only `force_wake` leaves off. The exit spends one cycle with only `sys_pwr_en` restored and then follows the R6 path.
- R10: `reg_vsel` equals `vsel_cfg` in active, idle, wait and the wait exit. It is forced to the top step (all ones) in backup, in off and on power-up exits, where `reg_ready` is meaningful.
- R11: A valid request received outside active mode is held, and the latest one replaces an earlier one. It is carried out starting on the edge after active mode is reached.
- R12: `mode_status` reads 0 for active, 1 for idle, 2 for wait, 3 for backup, 4 for off and 5 for any exit step. After reset it reads 0, with the outputs in their active values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Single-cycle mode request strobe |
| req_mode | input | 3 | Requested mode code |
| irq_wake | input | 1 | Interrupt wake pulse (idle exit) |
| fast_wake | input | 1 | Fast start-up pulse (wait exit) |
| bkp_wake | input | 1 | Backup wake-up pulse |
| force_wake | input | 1 | Force-wake pulse (off and backup exit) |
| osc_ready | input | 1 | Fast RC oscillator stable |
| reg_ready | input | 1 | Regulator output in range |
| bkp_sram_keep | input | 1 | Keep backup SRAM powered in backup |
| vsel_cfg | input | VSEL_W | Software regulator voltage step |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| mck_on_fastrc | output | 1 | Master clock source: 1 = fast RC, 0 = slow |
| fastrc_en | output | 1 | Fast RC oscillator enable |
| reg_mode | output | 2 | Regulator mode: 0 normal, 1 deep, 2 shutdown |
| reg_vsel | output | VSEL_W | Regulator voltage step |
| core_pwr_en | output | 1 | Core power switch |
| core_rst | output | 1 | Core and peripheral reset |
| sys_pwr_en | output | 1 | Supply-controller and slow-oscillator power |
| bkp_sram_en | output | 1 | Backup SRAM supply |
| pad_reinit | output | 1 | Pad reinitialisation pulse |
| wait_timeout | output | 1 | A ready wait ended on its timeout |
| mode_status | output | 3 | Current mode code |

## Verification
The bench builds the block with `TMO_CYCLES` = 4 and `VSEL_W` = 2. With these values a ready flag arriving early, exactly at the limit and never can each be reached within a few cycles. The bench sweeps the ready delay from 0 to `TMO_CYCLES`+1 for both the regulator wait and the oscillator wait, and compares each dwell time against min(delay, `TMO_CYCLES`-1)+1. It also applies all eight request codes from active mode and every wake pulse in every stable mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [3:0] {
    ST_ACT  = 4'd0,
    ST_IDLE = 4'd1,
    ST_WAIT = 4'd2,
    ST_BKP  = 4'd3,
    ST_OFF  = 4'd4,
    ST_WOSC = 4'd5,
    ST_OSUP = 4'd6,
    ST_PREG = 4'd7,
    ST_POSC = 4'd8,
    ST_PPAD = 4'd9
  } lpm_state_t;

  localparam logic [2:0] MODE_ACT    = 3'd0;
  localparam logic [2:0] MODE_IDLE   = 3'd1;
  localparam logic [2:0] MODE_WAIT   = 3'd2;
  localparam logic [2:0] MODE_BKP    = 3'd3;
  localparam logic [2:0] MODE_OFF    = 3'd4;
  localparam logic [2:0] MODE_WAKING = 3'd5;

  localparam logic [1:0] REG_NORMAL = 2'd0;
  localparam logic [1:0] REG_DEEP   = 2'd1;
  localparam logic [1:0] REG_SHUT   = 2'd2;

endpackage

// File: rtl/lpm_req_hold.sv
module lpm_req_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_mode,
  input  logic       take,
  output logic       pend_valid,
  output logic [2:0] pend_mode
);
  import lpm_pkg::*;

  logic code_ok;
  assign code_ok = (req_mode >= MODE_IDLE) && (req_mode <= MODE_OFF);

  // A fresh request wins over the consume of an older one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_mode  <= MODE_ACT;
    end else if (req_valid && code_ok) begin
      pend_valid <= 1'b1;
      pend_mode  <= req_mode;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_wait_timer.sv
module lpm_wait_timer #(
  parameter int TMO_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYCLES) + 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !run) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
  parameter int TMO_CYCLES = 1024,
  parameter int VSEL_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic              irq_wake,
  input  logic              fast_wake,
  input  logic              bkp_wake,
  input  logic              force_wake,
  input  logic              osc_ready,
  input  logic              reg_ready,
  input  logic              bkp_sram_keep,
  input  logic [VSEL_W-1:0] vsel_cfg,
  output logic              cpu_clk_en,
  output logic              mck_on_fastrc,
  output logic              fastrc_en,
  output logic [1:0]        reg_mode,
  output logic [VSEL_W-1:0] reg_vsel,
  output logic              core_pwr_en,
  output logic              core_rst,
  output logic              sys_pwr_en,
  output logic              bkp_sram_en,
  output logic              pad_reinit,
  output logic              wait_timeout,
  output logic [2:0]        mode_status
);
  import lpm_pkg::*;

  localparam logic [VSEL_W-1:0] VSEL_TOP = {VSEL_W{1'b1}};

  lpm_state_t st, nxt;
  logic       pend_valid;
  logic [2:0] pend_mode;
  logic       take;
  logic       tmr_run, tmr_exp, awaited;
  logic       keep_q;

  assign take = (st == ST_ACT) && pend_valid;

  lpm_req_hold u_hold (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .take(take), .pend_valid(pend_valid), .pend_mode(pend_mode)
  );

  assign tmr_run = (st == ST_WOSC) || (st == ST_PREG) || (st == ST_POSC);

  lpm_wait_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .clr(nxt != st), .expired(tmr_exp)
  );

  // Flag the current wait is looking for.
  always_comb begin
    unique case (st)
      ST_PREG: awaited = reg_ready;
      default: awaited = osc_ready;
    endcase
  end

  assign wait_timeout = tmr_exp && !awaited;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_ACT: if (pend_valid) begin
        unique case (pend_mode)
          MODE_IDLE: nxt = ST_IDLE;
          MODE_WAIT: nxt = ST_WAIT;
          MODE_BKP:  nxt = ST_BKP;
          default:   nxt = ST_OFF;
        endcase
      end
      ST_IDLE: if (irq_wake)                nxt = ST_ACT;
      ST_WAIT: if (fast_wake)               nxt = ST_WOSC;
      ST_WOSC: if (osc_ready || tmr_exp)    nxt = ST_ACT;
      ST_BKP:  if (bkp_wake || force_wake)  nxt = ST_PREG;
      ST_OFF:  if (force_wake)              nxt = ST_OSUP;
      ST_OSUP:                              nxt = ST_PREG;
      ST_PREG: if (reg_ready || tmr_exp)    nxt = ST_POSC;
      ST_POSC: if (osc_ready || tmr_exp)    nxt = ST_PPAD;
      ST_PPAD:                              nxt = ST_ACT;
      default:                              nxt = ST_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_ACT;
      keep_q <= 1'b1;
    end else begin
      st <= nxt;
      if (take && pend_mode == MODE_BKP) keep_q <= bkp_sram_keep;
    end
  end

  // Output decode, one row per state.
  always_comb begin
    cpu_clk_en    = 1'b0;
    mck_on_fastrc = 1'b0;
    fastrc_en     = 1'b0;
    reg_mode      = REG_NORMAL;
    reg_vsel      = VSEL_TOP;
    core_pwr_en   = 1'b1;
    core_rst      = 1'b1;
    sys_pwr_en    = 1'b1;
    bkp_sram_en   = 1'b1;
    pad_reinit    = 1'b0;
    mode_status   = MODE_WAKING;
    unique case (st)
      ST_ACT, ST_IDLE: begin
        cpu_clk_en    = (st == ST_ACT);
        mck_on_fastrc = 1'b1;
        fastrc_en     = 1'b1;
        reg_vsel      = vsel_cfg;
        core_rst      = 1'b0;
        mode_status   = (st == ST_ACT) ? MODE_ACT : MODE_IDLE;
      end
      ST_WAIT, ST_WOSC: begin
        fastrc_en   = (st == ST_WOSC);
        reg_mode    = (st == ST_WAIT) ? REG_DEEP : REG_NORMAL;
        reg_vsel    = vsel_cfg;
        core_rst    = 1'b0;
        mode_status = (st == ST_WAIT) ? MODE_WAIT : MODE_WAKING;
      end
      ST_BKP: begin
        reg_mode    = REG_SHUT;
        core_pwr_en = 1'b0;
        bkp_sram_en = keep_q;
        mode_status = MODE_BKP;
      end
      ST_OFF, ST_OSUP: begin
        reg_mode    = REG_SHUT;
        core_pwr_en = 1'b0;
        sys_pwr_en  = (st == ST_OSUP);
        bkp_sram_en = 1'b0;
        mode_status = (st == ST_OFF) ? MODE_OFF : MODE_WAKING;
      end
      ST_PREG: ;
      ST_POSC: fastrc_en = 1'b1;
      ST_PPAD: begin
        fastrc_en  = 1'b1;
        pad_reinit = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       force_wake,
  input logic       osc_ready,
  input logic       reg_ready,
  input logic       mck_on_fastrc,
  input logic       fastrc_en,
  input logic [1:0] reg_mode,
  input logic       core_pwr_en,
  input logic       core_rst,
  input logic       sys_pwr_en,
  input logic       pad_reinit,
  input logic       wait_timeout,
  input logic [2:0] mode_status
);
  // R4
  mck_after_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mck_on_fastrc) |-> $past(fastrc_en));

  // R6
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> ($past(core_pwr_en) && $past(reg_mode) == 2'd0));

  // R8
  pad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_reinit |=> !pad_reinit);

  // R9
  sys_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_pwr_en) |-> $past(force_wake));

  // R7
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_timeout |-> !(osc_ready && reg_ready));

  // R12
  status_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status <= 3'd5);
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (.*);

// File: tb/test_lpm_sequencer.sv
module test_lpm_sequencer;
  localparam int TMO = 4;
  localparam int VW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic irq_wake = 1'b0, fast_wake = 1'b0, bkp_wake = 1'b0, force_wake = 1'b0;
  logic osc_ready = 1'b1, reg_ready = 1'b1, bkp_sram_keep = 1'b0;
  logic [VW-1:0] vsel_cfg = 2'd1;
  logic cpu_clk_en, mck_on_fastrc, fastrc_en, core_pwr_en, core_rst;
  logic sys_pwr_en, bkp_sram_en, pad_reinit, wait_timeout;
  logic [1:0] reg_mode;
  logic [VW-1:0] reg_vsel;
  logic [2:0] mode_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_sequencer #(.TMO_CYCLES(TMO), .VSEL_W(VW)) i_lpm_sequencer (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_req(input int m);
    req_valid = 1'b1;
    req_mode  = 3'(m);
    tick(1);
    req_valid = 1'b0;
    tick(1);
  endtask

  // 0 irq, 1 fast, 2 backup, 3 force
  task automatic wake(input int w);
    irq_wake   = (w == 0);
    fast_wake  = (w == 1);
    bkp_wake   = (w == 2);
    force_wake = (w == 3);
    tick(1);
    irq_wake = 0; fast_wake = 0; bkp_wake = 0; force_wake = 0;
  endtask

  // Rest of a power-up exit once past the regulator step (ready flags high).
  task automatic finish_powerup(input string tag);
    check({tag, " osc step fastrc"}, fastrc_en, 1);
    check({tag, " osc step rst"}, core_rst, 1);
    check({tag, " osc step mck"}, mck_on_fastrc, 0);
    tick(1);
    check({tag, " R8 pad pulse"}, pad_reinit, 1);
    check({tag, " R8 rst held"}, core_rst, 1);
    tick(1);
    check({tag, " R8 pad drop"}, pad_reinit, 0);
    check({tag, " R6 active rst"}, core_rst, 0);
    check({tag, " R12 active"}, mode_status, 0);
  endtask

  // R6/R7 regulator wait sweep, starting from backup.
  task automatic meas_reg(input int d);
    int k = 0;
    int tmo = 0;
    int exp_dw = ((d < TMO - 1) ? d : TMO - 1) + 1;
    reg_ready = 1'b0;
    wake(2);
    check("R6 power step vsel", reg_vsel, 3);
    check("R6 power step sram", bkp_sram_en, 1);
    while (core_pwr_en && core_rst && !fastrc_en && k < 50) begin
      reg_ready = (k >= d);
      #1;
      if (wait_timeout) tmo++;
      check("R6 power step reg_mode", reg_mode, 0);
      tick(1);
      k++;
    end
    reg_ready = 1'b1;
    check($sformatf("R6 reg wait dwell d=%0d", d), k, exp_dw);
    check($sformatf("R7 reg timeout d=%0d", d), tmo, (d >= TMO) ? 1 : 0);
    finish_powerup("R6");
  endtask

  // R4/R7 oscillator wait sweep on the wait exit, starting from wait.
  task automatic meas_osc(input int d);
    int k = 0;
    int tmo = 0;
    int pads = 0;
    int exp_dw = ((d < TMO - 1) ? d : TMO - 1) + 1;
    osc_ready = 1'b0;
    wake(1);
    check("R4 exit reg normal", reg_mode, 0);
    while (fastrc_en && !mck_on_fastrc && mode_status == 3'd5 && k < 50) begin
      osc_ready = (k >= d);
      #1;
      if (wait_timeout) tmo++;
      if (pad_reinit) pads++;
      check("R4 cpu held off", cpu_clk_en, 0);
      tick(1);
      k++;
    end
    osc_ready = 1'b1;
    check($sformatf("R4 osc wait dwell d=%0d", d), k, exp_dw);
    check($sformatf("R7 osc timeout d=%0d", d), tmo, (d >= TMO) ? 1 : 0);
    check("R8 no pad on wait exit", pads, 0);
    check("R4 mck on fastrc", mck_on_fastrc, 1);
    check("R4 cpu on", cpu_clk_en, 1);
    check("R12 back active", mode_status, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R12 reset state
    check("R12 reset status", mode_status, 0);
    check("R12 reset cpu", cpu_clk_en, 1);
    check("R12 reset mck", mck_on_fastrc, 1);
    check("R12 reset rst", core_rst, 0);
    check("R10 active vsel", reg_vsel, 1);

    // R1 sweep of all request codes from active
    for (int m = 0; m < 8; m++) begin
      send_req(m);
      check($sformatf("R1 status code %0d", m), mode_status, (m >= 1 && m <= 4) ? m : 0);
      tick(3);
      check($sformatf("R1 settled code %0d", m), mode_status, (m >= 1 && m <= 4) ? m : 0);
      case (m)
        1: begin
          check("R2 idle cpu", cpu_clk_en, 0);
          check("R2 idle mck", mck_on_fastrc, 1);
          check("R2 idle fastrc", fastrc_en, 1);
          check("R10 idle vsel", reg_vsel, 1);
          wake(1); wake(2); wake(3);
          check("R2 other wakes ignored", mode_status, 1);
          wake(0);
          check("R2 irq exit", mode_status, 0);
          check("R2 irq exit cpu", cpu_clk_en, 1);
        end
        2: begin
          check("R3 wait reg deep", reg_mode, 1);
          check("R3 wait cpu", cpu_clk_en, 0);
          check("R3 wait fastrc", fastrc_en, 0);
          check("R3 wait mck", mck_on_fastrc, 0);
          check("R8 wait pad", pad_reinit, 0);
          check("R10 wait vsel", reg_vsel, 1);
          wake(0); wake(2); wake(3);
          check("R3 other wakes ignored", mode_status, 2);
          wake(1);
          check("R4 exit step", mode_status, 5);
          tick(1);
          check("R4 exit done", mode_status, 0);
        end
        3: begin
          check("R5 bkp reg shut", reg_mode, 2);
          check("R5 bkp core off", core_pwr_en, 0);
          check("R5 bkp rst", core_rst, 1);
          check("R5 bkp sys on", sys_pwr_en, 1);
          check("R5 bkp sram keep=0", bkp_sram_en, 0);
          check("R10 bkp vsel", reg_vsel, 3);
          check("R8 bkp pad", pad_reinit, 0);
          wake(0); wake(1);
          check("R5 irq/fast ignored", mode_status, 3);
          wake(3);
          check("R5 force exits bkp", mode_status, 5);
          tick(1);
          finish_powerup("R5");
        end
        4: begin
          check("R9 off sys", sys_pwr_en, 0);
          check("R9 off core", core_pwr_en, 0);
          check("R9 off sram", bkp_sram_en, 0);
          check("R9 off fastrc", fastrc_en, 0);
          check("R9 off reg", reg_mode, 2);
          wake(0); wake(1); wake(2);
          check("R9 other wakes ignored", mode_status, 4);
          wake(3);
          check("R9 supply step sys", sys_pwr_en, 1);
          check("R9 supply step core", core_pwr_en, 0);
          check("R9 supply step status", mode_status, 5);
          tick(1);
          check("R9 power step core", core_pwr_en, 1);
          check("R9 power step rst", core_rst, 1);
          tick(1);
          finish_powerup("R9");
        end
        default: check("R1 ignored code cpu", cpu_clk_en, 1);
      endcase
    end

    // R5 backup SRAM kept when requested on entry
    bkp_sram_keep = 1'b1;
    send_req(3);
    bkp_sram_keep = 1'b0;
    check("R5 bkp sram keep=1", bkp_sram_en, 1);
    wake(2);
    tick(1);
    finish_powerup("R5b");

    // R6/R7 regulator wait sweep
    for (int d = 0; d <= TMO + 1; d++) begin
      send_req(3);
      meas_reg(d);
    end

    // R4/R7 oscillator wait sweep
    for (int d = 0; d <= TMO + 1; d++) begin
      send_req(2);
      meas_osc(d);
    end

    // R11 request held outside active, latest wins
    send_req(1);
    send_req(3);
    send_req(2);
    check("R11 held while idle", mode_status, 1);
    wake(0);
    check("R11 active first", mode_status, 0);
    tick(1);
    check("R11 latest request runs", mode_status, 2);
    wake(1);
    tick(1);
    check("R11 no repeat", mode_status, 0);
    tick(2);
    check("R11 slot cleared", mode_status, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule